// File: doc/BRIEF.md
# Programmable Memory Strobe Output Stage

This block produces the active-low chip-select and byte-select strobes of an external memory bus for cycles run by a user-programmable memory machine. A sequencer outside the block presents one microcode word at a time. Each word carries four timing-phase bits for the chip-select and four for the byte-selects. With them come the accessed bank number, that bank's machine-select code, the bank's port size, the transfer size, the low address bits and a refresh flag.

An internal phase counter walks the four phases of each word, one per clock. A new word restarts it at the first phase. The selected bank's chip-select and the enabled byte lanes take the level of the current phase bit. Every other strobe is held high. The lanes that take part are worked out from the port width, the start offset and the transfer length, and are clipped at the edge of the port. A refresh request enables every lane. All outputs are registered.

Top module: `mem_strobe_stage`

## Requirements
- R1: The strobes are driven only when `run` is 1 and `mach_sel` equals 2 (the programmable-machine code). In any other cycle, every `cs_n_o` and `bs_n_o` bit is 1 one clock later. Codes 0, 1 and 3 belong to other machines.
- R2: When driven, `cs_n_o[bank]` takes the value of `cs_phase[k]` for the current phase k (bit 0 is the first phase), one clock after the inputs are sampled.
- R3: A clock with `word_start` high uses phase 0. Each following clock advances the phase by one, and after phase 3 it wraps to phase 0. A `word_start` in the middle of a word restarts at phase 0.
- R4: When driven, every enabled byte lane takes the level of `bs_phase[k]`, and every lane that is not enabled is 1.
- R5: Lanes are big-endian. `bs_n_o[i]` strobes data bits D[8i..8i+7], so lane 0 is the most significant byte. A port of width code p (0=8, 1=16, 2=32, 3=64 bits) occupies lanes 0 to 2^p-1.
- R6: The first enabled lane is `addr_lo` modulo the port's byte count. The lane count is 2^x bytes for `xfer_sz` code x (0=1, 1=2, 2=4, 3=8).
- R7: A transfer that would run past the last lane of the port is clipped, so no lane outside the port is enabled.
- R8: When `refresh` is 1, all eight lanes are enabled, whatever the port size, transfer size or address.
- R9: While `rst` is high, all outputs are 1 and the phase counter returns to phase 0. The first clock after reset uses phase 0 even without `word_start`.
- R10: At most one `cs_n_o` bit is 0 at any time, and that bit belongs to the accessed bank.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | Programmable machine is executing a word |
| word_start | input | 1 | First clock of a new microcode word |
| cs_phase | input | 4 | Chip-select level per timing phase |
| bs_phase | input | 4 | Byte-select level per timing phase |
| bank | input | 4 | Accessed bank number |
| mach_sel | input | 2 | Machine-select code of the accessed bank |
| port_sz | input | 2 | Port width code of the bank |
| xfer_sz | input | 2 | Transfer length code |
| addr_lo | input | 3 | Low address bits (byte offset) |
| refresh | input | 1 | Refresh-timer request |
| cs_n_o | output | 12 | Active-low chip-select per bank |
| bs_n_o | output | 8 | Active-low byte-select per lane |

## Verification
A hand-written table of lane masks anchors specific cases: full-width, single-byte, misaligned-and-clipped and refresh. This separates clipping mistakes from offset mistakes. The bench then sweeps every port, length and offset combination against a lane reference computed in the bench, across four phases with asymmetric phase bits, so a swapped or reversed phase order shows up. Directed runs cover the three non-programmable machine codes, an idle machine, phase wrap, mid-word restart and the highest bank. These separate ownership errors from sequencing errors.

// File: rtl/strobe_pkg.sv
package strobe_pkg;
  typedef enum logic [1:0] {
    MS_GENERAL = 2'd0,
    MS_SDRAM   = 2'd1,
    MS_PROG    = 2'd2,
    MS_SPARE   = 2'd3
  } mach_sel_e;

  localparam int STROBE_PHASES = 4;
endpackage

// File: rtl/strobe_phase_ctr.sv
module strobe_phase_ctr #(
  parameter int PHASES = 4,
  localparam int PH_W = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic            word_start,
  output logic [PH_W-1:0] phase_o
);
  logic [PH_W-1:0] ph_q;
  logic [PH_W-1:0] cur;

  assign cur     = word_start ? '0 : ph_q;
  assign phase_o = cur;

  always_ff @(posedge clk) begin
    if (rst)
      ph_q <= '0;
    else if (run)
      ph_q <= (cur == PH_W'(PHASES - 1)) ? '0 : cur + 1'b1;
  end

  // R3: a new word restarts the sequence, so the next phase is the second one
  p_phase_restart_r3: assert property (@(posedge clk) disable iff (rst)
    (run && word_start) |=> (ph_q == PH_W'(1 % PHASES)));

  // R3: within a word the phase steps by one
  p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
    (run && !word_start && ph_q != PH_W'(PHASES - 1)) |=> (ph_q == $past(ph_q) + 1'b1));
endmodule

// File: rtl/strobe_lane_mask.sv
module strobe_lane_mask #(
  parameter int NUM_LANES = 8,
  localparam int ADDR_W = $clog2(NUM_LANES),
  localparam int CNT_W  = ADDR_W + 2
) (
  input  logic [1:0]           port_sz,
  input  logic [1:0]           xfer_sz,
  input  logic [ADDR_W-1:0]    addr_lo,
  input  logic                 refresh,
  output logic [NUM_LANES-1:0] lane_en
);
  logic [2:0]       port_log;
  logic [2:0]       xfer_log;
  logic [CNT_W-1:0] port_lanes;
  logic [CNT_W-1:0] first;
  logic [CNT_W-1:0] stop;

  always_comb begin
    port_log = (int'(port_sz) > ADDR_W) ? 3'(ADDR_W) : 3'(port_sz);
    xfer_log = (int'(xfer_sz) > ADDR_W) ? 3'(ADDR_W) : 3'(xfer_sz);
    port_lanes = CNT_W'(1) << port_log;
    first = CNT_W'(addr_lo) & (port_lanes - CNT_W'(1));
    stop  = first + (CNT_W'(1) << xfer_log);
    if (stop > port_lanes)
      stop = port_lanes;
  end

  for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
    assign lane_en[i] = refresh | ((CNT_W'(i) >= first) & (CNT_W'(i) < stop));
  end
endmodule

// File: rtl/strobe_cs_decode.sv
module strobe_cs_decode #(
  parameter int NUM_BANKS = 12,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 hit,
  input  logic [BANK_W-1:0]    bank,
  output logic [NUM_BANKS-1:0] bank_sel
);
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_sel[b] = hit & (bank == BANK_W'(b));
  end
endmodule

// File: rtl/mem_strobe_stage.sv
module mem_strobe_stage
  import strobe_pkg::*;
#(
  parameter int NUM_BANKS = 12,
  parameter int NUM_LANES = 8,
  parameter int PHASES    = STROBE_PHASES,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W = $clog2(NUM_LANES),
  localparam int PH_W   = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 run,
  input  logic                 word_start,
  input  logic [PHASES-1:0]    cs_phase,
  input  logic [PHASES-1:0]    bs_phase,
  input  logic [BANK_W-1:0]    bank,
  input  logic [1:0]           mach_sel,
  input  logic [1:0]           port_sz,
  input  logic [1:0]           xfer_sz,
  input  logic [ADDR_W-1:0]    addr_lo,
  input  logic                 refresh,
  output logic [NUM_BANKS-1:0] cs_n_o,
  output logic [NUM_LANES-1:0] bs_n_o
);
  logic                 hit;
  logic [PH_W-1:0]      phase;
  logic                 cs_lvl;
  logic                 bs_lvl;
  logic [NUM_BANKS-1:0] bank_sel;
  logic [NUM_LANES-1:0] lane_en;
  logic [NUM_BANKS-1:0] cs_n_d;
  logic [NUM_LANES-1:0] bs_n_d;

  assign hit = run & (mach_sel == MS_PROG);

  strobe_phase_ctr #(.PHASES(PHASES)) u_phase (
    .clk(clk), .rst(rst), .run(run), .word_start(word_start), .phase_o(phase)
  );

  strobe_cs_decode #(.NUM_BANKS(NUM_BANKS)) u_csdec (
    .hit(hit), .bank(bank), .bank_sel(bank_sel)
  );

  strobe_lane_mask #(.NUM_LANES(NUM_LANES)) u_lanes (
    .port_sz(port_sz), .xfer_sz(xfer_sz), .addr_lo(addr_lo),
    .refresh(refresh), .lane_en(lane_en)
  );

  assign cs_lvl = cs_phase[phase];
  assign bs_lvl = bs_phase[phase];
  assign cs_n_d = ~bank_sel | {NUM_BANKS{cs_lvl}};
  assign bs_n_d = ~(lane_en & {NUM_LANES{hit}}) | {NUM_LANES{bs_lvl}};

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_n_o <= '1;
      bs_n_o <= '1;
    end else begin
      cs_n_o <= cs_n_d;
      bs_n_o <= bs_n_d;
    end
  end

  // R1: any cycle not owned by the programmable machine leaves all strobes high
  p_idle_high_r1: assert property (@(posedge clk) disable iff (rst)
    !hit |=> (cs_n_o == '1 && bs_n_o == '1));

  // R10: never more than one bank selected
  p_cs_single_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~cs_n_o));

  // R2: the accessed bank follows the phase bit of the word
  p_cs_level_r2: assert property (@(posedge clk) disable iff (rst)
    (hit && int'(bank) < NUM_BANKS) |=> (cs_n_o[$past(bank)] == $past(cs_phase[phase])));

  // R8: refresh moves all lanes together
  p_refresh_all_r8: assert property (@(posedge clk) disable iff (rst)
    (hit && refresh) |=> (bs_n_o == '0 || bs_n_o == '1));

  // R7: no more lanes active than the port holds
  p_port_clip_r7: assert property (@(posedge clk) disable iff (rst)
    (hit && !refresh) |=> ($countones(~bs_n_o) <= (1 << $past(port_sz))));
endmodule

// File: tb/test_mem_strobe_stage.sv
module test_mem_strobe_stage;
  logic        clk = 1'b0;
  logic        rst;
  logic        run;
  logic        word_start;
  logic [3:0]  cs_phase;
  logic [3:0]  bs_phase;
  logic [3:0]  bank;
  logic [1:0]  mach_sel;
  logic [1:0]  port_sz;
  logic [1:0]  xfer_sz;
  logic [2:0]  addr_lo;
  logic        refresh;
  logic [11:0] cs_n_o;
  logic [7:0]  bs_n_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  mem_strobe_stage i_mem_strobe_stage (
    .clk(clk), .rst(rst), .run(run), .word_start(word_start),
    .cs_phase(cs_phase), .bs_phase(bs_phase), .bank(bank),
    .mach_sel(mach_sel), .port_sz(port_sz), .xfer_sz(xfer_sz),
    .addr_lo(addr_lo), .refresh(refresh), .cs_n_o(cs_n_o), .bs_n_o(bs_n_o)
  );

  // {port_sz, xfer_sz, addr_lo, refresh, expected lane mask (bit i = lane i)}
  localparam logic [15:0] VEC [12] = '{
    {2'd3, 2'd3, 3'd0, 1'b0, 8'hFF},
    {2'd3, 2'd0, 3'd5, 1'b0, 8'h20},
    {2'd3, 2'd1, 3'd6, 1'b0, 8'hC0},
    {2'd3, 2'd2, 3'd4, 1'b0, 8'hF0},
    {2'd2, 2'd2, 3'd0, 1'b0, 8'h0F},
    {2'd2, 2'd0, 3'd3, 1'b0, 8'h08},
    {2'd2, 2'd1, 3'd3, 1'b0, 8'h08},
    {2'd1, 2'd0, 3'd1, 1'b0, 8'h02},
    {2'd1, 2'd3, 3'd0, 1'b0, 8'h03},
    {2'd0, 2'd2, 3'd7, 1'b0, 8'h01},
    {2'd2, 2'd3, 3'd6, 1'b0, 8'h0C},
    {2'd0, 2'd0, 3'd3, 1'b1, 8'hFF}
  };

  function automatic logic [7:0] ref_mask(int ps, int xs, int a, bit r);
    logic [7:0] m = '0;
    int pw = 1 << ps;
    int st = a % pw;
    int n  = 1 << xs;
    if (r) return 8'hFF;
    for (int i = 0; i < 8; i++)
      if (i >= st && i < st + n && i < pw) m[i] = 1'b1;
    return m;
  endfunction

  task automatic check(input logic [11:0] exp_cs, input logic [7:0] exp_bs, input string tag);
    n_checks++;
    if (cs_n_o !== exp_cs || bs_n_o !== exp_bs) begin
      n_fail++;
      $display("FAIL %s: cs_n=%h bs_n=%h expected cs_n=%h bs_n=%h",
               tag, cs_n_o, bs_n_o, exp_cs, exp_bs);
    end
  endtask

  // one clock; expected result for phase k under the currently driven inputs
  task automatic step(input logic ws, input int k, input logic [7:0] mask, input string tag);
    logic [11:0] ec = '1;
    logic [7:0]  eb = '1;
    word_start = ws;
    @(posedge clk);
    @(negedge clk);
    if (run && mach_sel == 2'd2) begin
      ec[bank] = cs_phase[k];
      for (int i = 0; i < 8; i++) if (mask[i]) eb[i] = bs_phase[k];
    end
    check(ec, eb, $sformatf("%s phase%0d", tag, k));
  endtask

  task automatic word(input logic [7:0] mask, input string tag);
    for (int k = 0; k < 4; k++) step(k == 0, k, mask, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; run = 1'b1; word_start = 1'b1; cs_phase = 4'b1100; bs_phase = 4'b1000;
    bank = 4'd2; mach_sel = 2'd2; port_sz = 2'd3; xfer_sz = 2'd3; addr_lo = 3'd0; refresh = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check('1, '1, "R9 reset holds strobes high");
    rst = 1'b0;
    // R9/R3: first clock after reset is phase 0 without word_start
    step(1'b0, 0, 8'hFF, "R9 post-reset phase");
    step(1'b0, 1, 8'hFF, "R3 step");

    // R4 R5 R6 R7 R8: table of directed lane masks
    for (int v = 0; v < 12; v++) begin
      {port_sz, xfer_sz, addr_lo, refresh} = VEC[v][15:8];
      bank = 4'(v % 12);
      word(VEC[v][7:0], $sformatf("R5 R6 R7 R8 table %0d", v));
    end

    // R2 R4 R6 R7: every port/length/offset combination
    cs_phase = 4'b0010; bs_phase = 4'b1110; refresh = 1'b0;
    for (int c = 0; c < 128; c++) begin
      port_sz = 2'(c >> 5); xfer_sz = 2'(c >> 3); addr_lo = 3'(c);
      bank = 4'(c % 12);
      word(ref_mask(c >> 5, (c >> 3) & 3, c & 7, 1'b0), $sformatf("R6 R7 sweep %0d", c));
    end

    // R1: other machine codes own the cycle
    port_sz = 2'd3; xfer_sz = 2'd3; addr_lo = 3'd0; bank = 4'd3;
    cs_phase = 4'b0000; bs_phase = 4'b0000;
    for (int m = 0; m < 4; m++) begin
      if (m == 2) continue;
      mach_sel = 2'(m);
      word(8'hFF, $sformatf("R1 mach_sel=%0d", m));
    end
    // R1: idle machine
    mach_sel = 2'd2; run = 1'b0;
    word(8'hFF, "R1 idle");
    run = 1'b1;

    // R3: wrap after phase 3, and mid-word restart
    cs_phase = 4'b0110; bs_phase = 4'b0101;
    word(8'hFF, "R3 word");
    step(1'b0, 0, 8'hFF, "R3 wrap");
    step(1'b0, 1, 8'hFF, "R3 wrap");
    step(1'b1, 0, 8'hFF, "R3 restart");
    step(1'b0, 1, 8'hFF, "R3 restart");

    // R10: highest bank, only its select moves
    bank = 4'd11; cs_phase = 4'b0000;
    word(8'hFF, "R10 bank11");

    // R8: refresh with narrow port and single byte
    refresh = 1'b1; port_sz = 2'd0; xfer_sz = 2'd0; addr_lo = 3'd5; bs_phase = 4'b0011;
    word(8'hFF, "R8 refresh narrow");
    refresh = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule